// File: doc/BRIEF.md
# Frame-Synchronised Serial Word Receiver

This block receives 16-bit command words over a three-wire serial link: a serial clock, an active-low frame select and a data line. The transmitter lowers frame select, clocks in sixteen bits with the most significant bit first, and raises frame select again. The word is handed to a downstream decoder only when frame select rises, never on the sixteenth clock. A frame may arrive as one unbroken burst or as two bytes with an idle clock gap between them, as long as frame select stays low throughout. The upper byte of the word is the control field and the lower byte the data field; this block does not look inside either.

All three serial lines are asynchronous to the system clock. Each passes through a two-stage synchroniser, and edges are found by comparing the synchronised value with its value one cycle earlier. The system clock must run at least four times faster than the serial clock. A frame that ends with a bit count other than sixteen is discarded and reported with a one-cycle error pulse.

The controller has three states. IDLE waits with frame select high. A falling frame select moves IDLE to SHIFT and clears the bit count. In SHIFT each rising serial clock shifts one bit in; the sixteenth bit moves SHIFT to FULL. A rising frame select in SHIFT returns to IDLE and raises the error pulse. In FULL further serial clocks are ignored, and a rising frame select returns to IDLE and commits the word.

Top module: `sync_frame_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, word_valid and frame_error are 0 and word is 16'h0000.
- R2: The first bit clocked in after frame select falls lands in word bit 15 and the sixteenth in bit 0; a sixteen-bit frame gives one word_valid pulse carrying that word.
- R3: A frame sent as two 8-bit bursts separated by an idle serial clock gap, with frame select low throughout, yields the same word as a continuous burst.
- R4: Serial clock edges after the sixteenth within one frame are ignored: the committed word holds the first sixteen bits.
- R5: When frame select rises after fewer than sixteen bits, frame_error pulses for one cycle, word_valid stays 0 and word keeps its previous value.
- R6: Serial clock edges while frame select is high shift nothing; the next frame still starts from bit count zero.
- R7: word_valid and frame_error each last exactly one system clock cycle, are never high together, and word changes only in a cycle where word_valid is high.
- R8: If frame select is first sampled high at system clock edge k, word_valid or frame_error is high in the cycle after edge k+2 and low in the cycle before.
- R9: A short frame does not disturb the next one: the bit count restarts when frame select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock, asynchronous, data taken on its rising edge |
| sync_n_in | input | 1 | Active-low frame select, asynchronous |
| din_in | input | 1 | Serial data, most significant bit first |
| word_valid | output | 1 | One-cycle pulse when a complete word is committed |
| word | output | 16 | Last committed word, held between frames |
| frame_error | output | 1 | One-cycle pulse when a frame ends with the wrong bit count |

## Verification
The bench goes after the split-byte frame, where a design that committed or restarted on a clock gap would lose the lower byte, and the over-long frame, where a design that kept shifting would commit the last sixteen bits instead of the first. It sends short frames, where a design committing on any frame-select rise would overwrite the word instead of raising the error pulse, and then a good frame, which exposes a counter not cleared on the next falling frame select. Serial clocks with frame select high catch a receiver that shifts outside a frame, and a fixed-latency check on the strobes catches an extra or missing register stage in the synchroniser or edge path.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } rx_state_e;

    // bit positions inside the synchronised input vector
    localparam int unsigned PIN_SYNC = 0;
    localparam int unsigned PIN_SCLK = 1;
    localparam int unsigned PIN_DIN  = 2;
    localparam int unsigned PIN_CNT  = 3;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/sfr_edge.sv
module sfr_edge #(
    parameter int unsigned WIDTH = 1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0,
    parameter bit RISING = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] pulse
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RESET_VAL;
        end else begin
            prev_q <= level;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = level & ~prev_q;
        end else begin : g_fall
            assign pulse = ~level & prev_q;
        end
    endgenerate

endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] shift_word,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              last_bit
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            cnt_q  <= '0;
        end else if (shift_en) begin
            sreg_q <= {sreg_q[WORD_W-2:0], bit_in};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign shift_word = sreg_q;
    assign bit_cnt    = cnt_q;
    assign last_bit   = (cnt_q == LAST_IDX);

endmodule

// File: rtl/sfr_fsm.sv
module sfr_fsm
    import sfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_stop,
    input  logic bit_strobe,
    input  logic last_bit,
    output logic clear_cnt,
    output logic shift_en,
    output logic commit,
    output logic abort
);

    rx_state_e state_q;
    rx_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (frame_stop)                  state_d = ST_IDLE;
                else if (bit_strobe && last_bit) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (frame_stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // control outputs
    always_comb begin
        clear_cnt = 1'b0;
        shift_en  = 1'b0;
        commit    = 1'b0;
        abort     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clear_cnt = frame_start;
            end
            ST_SHIFT: begin
                abort    = frame_stop;
                shift_en = bit_strobe && !frame_stop;
            end
            ST_FULL: begin
                commit = frame_stop;
            end
            default: begin
                clear_cnt = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
    import sfr_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sync_n_in,
    input  logic              din_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic              frame_error
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [PIN_CNT-1:0] IDLE_PINS = PIN_CNT'(1) << PIN_SYNC;

    logic [PIN_CNT-1:0] raw_pins;
    logic [PIN_CNT-1:0] pins_s;
    logic [1:0]         rise_pulse;
    logic [0:0]         fall_pulse;

    logic              clear_cnt;
    logic              shift_en;
    logic              commit;
    logic              abort;
    logic              last_bit;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shift_word;

    logic              valid_q;
    logic              error_q;
    logic [WORD_W-1:0] word_q;

    always_comb begin
        raw_pins           = '0;
        raw_pins[PIN_SYNC] = sync_n_in;
        raw_pins[PIN_SCLK] = sclk_in;
        raw_pins[PIN_DIN]  = din_in;
    end

    sfr_sync #(
        .WIDTH     (PIN_CNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (IDLE_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_pins),
        .sync_out (pins_s)
    );

    // bit 0: frame select end, bit 1: serial clock rise
    sfr_edge #(
        .WIDTH     (2),
        .RESET_VAL (2'b01),
        .RISING    (1'b1)
    ) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({pins_s[PIN_SCLK], pins_s[PIN_SYNC]}),
        .pulse (rise_pulse)
    );

    sfr_edge #(
        .WIDTH     (1),
        .RESET_VAL (1'b1),
        .RISING    (1'b0)
    ) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pins_s[PIN_SYNC]),
        .pulse (fall_pulse)
    );

    sfr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (fall_pulse[0]),
        .frame_stop  (rise_pulse[0]),
        .bit_strobe  (rise_pulse[1]),
        .last_bit    (last_bit),
        .clear_cnt   (clear_cnt),
        .shift_en    (shift_en),
        .commit      (commit),
        .abort       (abort)
    );

    sfr_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_cnt),
        .shift_en   (shift_en),
        .bit_in     (pins_s[PIN_DIN]),
        .shift_word (shift_word),
        .bit_cnt    (bit_cnt),
        .last_bit   (last_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            error_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= commit;
            error_q <= abort;
            if (commit) word_q <= shift_word;
        end
    end

    assign word_valid  = valid_q;
    assign frame_error = error_q;
    assign word        = word_q;

endmodule

module sync_frame_rx_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid,
    input logic              frame_error,
    input logic [WORD_W-1:0] word,
    input logic [CNT_W-1:0]  bit_cnt
);

    // R7
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R7
    a_r7_error_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |=> !frame_error);

    // R7
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && frame_error));

    // R7
    a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word));

    // R4
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) <= WORD_W);

    // R2
    a_r2_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> int'($past(bit_cnt)) == WORD_W);

    // R5
    a_r5_short_count: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> int'($past(bit_cnt)) != WORD_W);

endmodule

bind sync_frame_rx sync_frame_rx_chk #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .frame_error (frame_error),
    .word        (word),
    .bit_cnt     (bit_cnt)
);

// File: tb/sync_frame_rx_test.sv
`timescale 1ns/1ps
module sync_frame_rx_test;

    localparam int H = 4; // serial clock half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0;
    logic        sync_n_in = 1'b1;
    logic        din_in = 1'b0;
    logic        word_valid;
    logic [15:0] word;
    logic        frame_error;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sync_frame_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_in     (sclk_in),
        .sync_n_in   (sync_n_in),
        .din_in      (din_in),
        .word_valid  (word_valid),
        .word        (word),
        .frame_error (frame_error)
    );

    // ---------------- behavioural reference ----------------
    bit          hs_sync[$];
    bit          hs_sclk[$];
    bit          hs_din[$];
    bit          m_active;
    int          m_count;
    bit [15:0]   m_shift;
    bit [15:0]   m_word;
    bit          m_valid;
    bit          m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            hs_sync = '{1, 1, 1, 1};
            hs_sclk = '{0, 0, 0, 0};
            hs_din  = '{0, 0, 0, 0};
            m_active = 0; m_count = 0; m_shift = '0; m_word = '0;
            m_valid = 0; m_err = 0;
        end else begin
            hs_sync.push_front(sync_n_in); void'(hs_sync.pop_back());
            hs_sclk.push_front(sclk_in);   void'(hs_sclk.pop_back());
            hs_din.push_front(din_in);     void'(hs_din.pop_back());
            m_valid = 0;
            m_err   = 0;
            if (!hs_sync[2] && hs_sync[3]) begin
                m_active = 1;
                m_count  = 0;
            end else if (hs_sync[2] && !hs_sync[3] && m_active) begin
                if (m_count == 16) begin
                    m_word  = m_shift;
                    m_valid = 1;
                end else begin
                    m_err = 1;
                end
                m_active = 0;
            end else if (m_active && !hs_sync[2] && hs_sclk[2] && !hs_sclk[3]
                         && m_count < 16) begin
                m_shift = {m_shift[14:0], hs_din[2]};
                m_count++;
            end
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({word_valid, frame_error} == {m_valid, m_err}, "R8 strobes vs model",
                {30'd0, word_valid, frame_error}, {30'd0, m_valid, m_err});
            chk(word == m_word, "R2 word vs model", {16'd0, word}, {16'd0, m_word});
        end
    end

    // ---------------- stimulus ----------------
    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        sync_n_in = 1'b0;
        clk_n(4);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            din_in = v[i];
            clk_n(H);
            sclk_in = 1'b1;
            clk_n(H);
            sclk_in = 1'b0;
        end
    endtask

    task automatic frame_end(input bit good, input string req);
        clk_n(H);
        sync_n_in = 1'b1;
        clk_n(2);
        chk(!word_valid && !frame_error, "R8 early strobe",
            {30'd0, word_valid, frame_error}, 32'd0);
        clk_n(1);
        if (good)
            chk(word_valid && !frame_error, req, {30'd0, word_valid, frame_error}, 32'd2);
        else
            chk(frame_error && !word_valid, req, {30'd0, word_valid, frame_error}, 32'd1);
        clk_n(1);
        chk(!word_valid && !frame_error, "R7 single pulse",
            {30'd0, word_valid, frame_error}, 32'd0);
        clk_n(6);
    endtask

    initial begin
        clk_n(5);
        chk(!word_valid && !frame_error && word == 16'h0, "R1 in reset",
            {13'd0, word_valid, frame_error, 1'b0, word}, 32'd0);
        rst_n = 1'b1;
        clk_n(1);
        chk(!word_valid && !frame_error && word == 16'h0, "R1 after reset",
            {13'd0, word_valid, frame_error, 1'b0, word}, 32'd0);
        clk_n(5);

        // R2 continuous frame
        frame_begin(); shift_bits(32'hA55A, 16); frame_end(1'b1, "R2 valid");
        chk(word == 16'hA55A, "R2 word", {16'd0, word}, 32'hA55A);

        // R3 two bytes with a gap
        frame_begin(); shift_bits(32'h3C, 8); clk_n(20); shift_bits(32'h81, 8);
        frame_end(1'b1, "R3 valid");
        chk(word == 16'h3C81, "R3 word", {16'd0, word}, 32'h3C81);

        // R4 extra bits ignored
        frame_begin(); shift_bits(32'hF00F, 16); shift_bits(32'hA, 4);
        frame_end(1'b1, "R4 valid");
        chk(word == 16'hF00F, "R4 word", {16'd0, word}, 32'hF00F);

        // R5 short frame
        frame_begin(); shift_bits(32'h155, 10); frame_end(1'b0, "R5 error");
        chk(word == 16'hF00F, "R5 word kept", {16'd0, word}, 32'hF00F);

        // R5 frame with no clocks at all
        frame_begin(); frame_end(1'b0, "R5 empty frame");

        // R6 clocks while frame select high
        din_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk_in = 1'b1; clk_n(H); sclk_in = 1'b0; clk_n(H);
        end
        chk(word == 16'hF00F && !word_valid, "R6 idle clocks",
            {16'd0, word}, 32'hF00F);

        // R9 good frame right after short ones
        frame_begin(); shift_bits(32'h0001, 16); frame_end(1'b1, "R9 valid");
        chk(word == 16'h0001, "R9 word", {16'd0, word}, 32'h0001);

        // extremes
        frame_begin(); shift_bits(32'hFFFF, 16); frame_end(1'b1, "R2 all ones");
        chk(word == 16'hFFFF, "R2 all ones word", {16'd0, word}, 32'hFFFF);
        frame_begin(); shift_bits(32'h0000, 16); frame_end(1'b1, "R2 all zeros");
        chk(word == 16'h0000, "R2 all zeros word", {16'd0, word}, 32'h0);

        // R7 word held over idle time
        clk_n(30);
        chk(word == 16'h0000 && !word_valid, "R7 hold", {16'd0, word}, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule